// File: doc/BRIEF.md
# Lookup-Table Bit-Serial Dot Product

This block computes the scalar product of N fixed-point inputs with a fixed set of weights, and it uses no multiplier. A controller first loads a table of precomputed sums through a write port. For every address, the table word is the sum of the scaled weight mantissas whose address bit is set, so address zero holds zero. Bit j of an address stands for input j.

A computation then takes one bit slice per accepted cycle. A slice holds one bit from each input, and slices arrive starting with the least significant bit. The slice addresses the table. An internal accumulator halves its running value and adds the table word. After M slices the block pulses `done` and shows an unsigned mantissa together with a shared exponent. The exponent is the caller's largest common weight exponent plus a fixed number of guard bits.

Two split variants are available. Both divide the inputs into a low group and a high group, and each group has its own smaller table. In the dual-memory variant the two tables are read and summed in the same cycle. In the single-memory variant the two reads share one array, so each slice takes two cycles.

Top module: `lut_dot_serial`

## Requirements
- R1: In full mode (SPLIT=0), a write to address A stores the word that a later slice equal to A reads. Bit j of the address stands for input j.
- R2: Slices are taken least significant bit first. For M=2, a result with slices (s0 then s1) equals (T[s0] + 2*T[s1]) >> 1.
- R3: The accumulator starts at zero on a start and computes acc = acc/2 + T[slice] per step, holding M guard fraction bits. The output mantissa has W_W+1 bits and equals floor(sum_i T[s_i]*2^i / 2^(M-1)).
- R4: `done` is high for exactly the one cycle after the M-th accumulation, and `res_mant` is valid in that cycle. A start presented in the `done` cycle is accepted.
- R5: While idle, a slice with `in_valid` high and `in_start` low is ignored. While running, `in_start` is treated as ordinary data. `busy` is high from the cycle after a start until `done`.
- R6: Table writes are ignored in the cycle a start is accepted and in every cycle that `busy` is high.
- R7: In the `done` cycle, `res_exp` equals `exp_in` as sampled at the start plus GUARD_Q, modulo 2^EXP_W.
- R8: In SPLIT=1, address bit N-1 selects the table (0 for the low inputs 0..N/2-1, 1 for the high inputs), and the low address bits give the index. The word used is the sum of the two group words, and the timing is the same as in full mode.
- R9: In SPLIT=2, one array holds both groups and is written with the same address format as R8. Each slice takes two cycles, and `slice_ready` is low during the second cycle. Results equal those of full mode.
- R10: After reset, `busy` and `done` are low, `slice_ready` is high, and `res_mant` and `res_exp` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | N_IN | Table write address |
| tbl_wdata | input | W_W | Table write word |
| exp_in | input | EXP_W | Common weight exponent, sampled at start |
| in_valid | input | 1 | Slice valid |
| in_start | input | 1 | Marks the first (least significant) slice |
| in_slice | input | N_IN | One bit from each input |
| slice_ready | output | 1 | Slice can be taken this cycle |
| busy | output | 1 | Computation in progress |
| done | output | 1 | Result valid pulse |
| res_mant | output | W_W+1 | Result mantissa |
| res_exp | output | EXP_W | Result exponent |

## Verification
A corrupt table word or accumulator value shows up as a wrong mantissa in the very next `done` cycle. The bench predicts every one of these cycles. A stray count or state error moves `done` or `busy` by at least one cycle, and the cycle-by-cycle model flags it at once. Blocked writes are checked by reading the targeted addresses back through later computations.

// File: rtl/lds_pkg.sv
package lds_pkg;
    localparam int LDS_FULL       = 0;
    localparam int LDS_SPLIT_DUAL = 1;
    localparam int LDS_SPLIT_SEQ  = 2;

    typedef enum logic [1:0] {
        LDS_IDLE = 2'd0,
        LDS_RUN  = 2'd1,
        LDS_HALF = 2'd2
    } lds_state_e;
endpackage

// File: rtl/lds_ctrl.sv
module lds_ctrl
    import lds_pkg::*;
#(
    parameter int M_BITS  = 2,
    parameter bit TWO_CYC = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_start,
    output logic acc_step,
    output logic acc_clr,
    output logic half_latch,
    output logic start_acc,
    output logic slice_ready,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(M_BITS + 1);

    typedef struct packed {
        lds_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             first;
        logic             done;
    } ctl_t;

    ctl_t             q, d;
    logic [CNT_W-1:0] cnt_nx;

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        acc_step   = 1'b0;
        acc_clr    = 1'b0;
        half_latch = 1'b0;
        start_acc  = 1'b0;
        cnt_nx     = q.cnt;
        case (q.state)
            LDS_IDLE: begin
                if (in_valid && in_start) begin
                    start_acc = 1'b1;
                    if (TWO_CYC) begin
                        half_latch = 1'b1;
                        d.first    = 1'b1;
                        d.state    = LDS_HALF;
                    end else begin
                        acc_step = 1'b1;
                        acc_clr  = 1'b1;
                    end
                end
            end
            LDS_RUN: begin
                if (in_valid) begin
                    if (TWO_CYC) begin
                        half_latch = 1'b1;
                        d.state    = LDS_HALF;
                    end else begin
                        acc_step = 1'b1;
                    end
                end
            end
            LDS_HALF: begin
                acc_step = 1'b1;
                acc_clr  = q.first;
                d.first  = 1'b0;
            end
            default: d.state = LDS_IDLE;
        endcase
        if (acc_step) begin
            cnt_nx = acc_clr ? CNT_W'(1) : q.cnt + 1'b1;
            if (cnt_nx == CNT_W'(M_BITS)) begin
                d.cnt   = '0;
                d.done  = 1'b1;
                d.state = LDS_IDLE;
            end else begin
                d.cnt   = cnt_nx;
                d.state = LDS_RUN;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{state: LDS_IDLE, cnt: '0, first: 1'b0, done: 1'b0};
        else        q <= d;
    end

    assign slice_ready = (q.state != LDS_HALF);
    assign busy        = (q.state != LDS_IDLE);
    assign done        = q.done;

    // R4: the result pulse coincides with the return to idle
    p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R4: the pulse follows an accumulation step
    p_done_after_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(acc_step));
    // R2: never more than M slices per result
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt < CNT_W'(M_BITS));
    // R9: the second read phase lasts one cycle
    p_half_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == LDS_HALF) |=> (q.state != LDS_HALF));
endmodule

// File: rtl/lds_table.sv
module lds_table
    import lds_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int W_W   = 32,
    parameter int SPLIT = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [N_IN-1:0] wr_addr,
    input  logic [W_W-1:0]  wr_data,
    input  logic [N_IN-1:0] rd_slice,
    input  logic            half_latch,
    output logic [W_W-1:0]  rd_word
);
    localparam int LO_W = N_IN / 2;
    localparam int HI_W = N_IN - LO_W;

    generate
        if (SPLIT == LDS_FULL) begin : g_full
            localparam int DEPTH = 1 << N_IN;
            logic [W_W-1:0] mem_q [DEPTH];
            logic [W_W-1:0] mem_d [DEPTH];
            logic           unused_latch;

            assign unused_latch = half_latch;

            always_comb begin
                mem_d = mem_q;
                if (wr_en) mem_d[wr_addr] = wr_data;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
                end else begin
                    mem_q <= mem_d;
                end
            end

            assign rd_word = mem_q[rd_slice];
        end else if (SPLIT == LDS_SPLIT_DUAL) begin : g_dual
            localparam int LO_D = 1 << LO_W;
            localparam int HI_D = 1 << HI_W;
            logic [W_W-1:0]  lo_q [LO_D];
            logic [W_W-1:0]  lo_d [LO_D];
            logic [W_W-1:0]  hi_q [HI_D];
            logic [W_W-1:0]  hi_d [HI_D];
            logic [HI_W-1:0] w_idx;
            logic            w_grp;
            logic            unused_bits;

            assign unused_bits = half_latch ^ (^wr_addr);
            assign w_grp = wr_addr[N_IN-1];
            assign w_idx = wr_addr[HI_W-1:0];

            always_comb begin
                lo_d = lo_q;
                hi_d = hi_q;
                if (wr_en) begin
                    if (w_grp) hi_d[w_idx]           = wr_data;
                    else       lo_d[w_idx[LO_W-1:0]] = wr_data;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < LO_D; i++) lo_q[i] <= '0;
                    for (int i = 0; i < HI_D; i++) hi_q[i] <= '0;
                end else begin
                    lo_q <= lo_d;
                    hi_q <= hi_d;
                end
            end

            assign rd_word = lo_q[rd_slice[LO_W-1:0]] + hi_q[rd_slice[N_IN-1:LO_W]];
        end else begin : g_seq
            localparam int AW    = HI_W + 1;
            localparam int DEPTH = 1 << AW;
            logic [W_W-1:0]  mem_q [DEPTH];
            logic [W_W-1:0]  mem_d [DEPTH];
            logic [W_W-1:0]  part_q, part_d;
            logic [HI_W-1:0] hidx_q, hidx_d;
            logic            unused_bits;

            assign unused_bits = ^wr_addr;

            always_comb begin
                mem_d  = mem_q;
                part_d = part_q;
                hidx_d = hidx_q;
                if (wr_en) mem_d[{wr_addr[N_IN-1], wr_addr[HI_W-1:0]}] = wr_data;
                if (half_latch) begin
                    part_d = mem_q[{1'b0, HI_W'(rd_slice[LO_W-1:0])}];
                    hidx_d = rd_slice[N_IN-1:LO_W];
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
                    part_q <= '0;
                    hidx_q <= '0;
                end else begin
                    mem_q  <= mem_d;
                    part_q <= part_d;
                    hidx_q <= hidx_d;
                end
            end

            assign rd_word = part_q + mem_q[{1'b1, hidx_q}];
        end
    endgenerate
endmodule

// File: rtl/lds_accum.sv
module lds_accum #(
    parameter int W_W    = 32,
    parameter int M_BITS = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step,
    input  logic           clr,
    input  logic [W_W-1:0] word,
    output logic [W_W:0]   mant
);
    localparam int ACC_W = W_W + 1 + M_BITS;

    logic [ACC_W-1:0] acc_q, acc_d;

    always_comb begin
        acc_d = acc_q;
        if (step) acc_d = (clr ? '0 : (acc_q >> 1)) + (ACC_W'(word) << M_BITS);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign mant = acc_q[ACC_W-1:M_BITS];

    // R3: a first step loads the table word with no earlier residue
    p_clear_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && clr) |=> (mant == {1'b0, $past(word)}));
endmodule

// File: rtl/lut_dot_serial.sv
module lut_dot_serial
    import lds_pkg::*;
#(
    parameter int N_IN    = 4,
    parameter int M_BITS  = 2,
    parameter int W_W     = 32,
    parameter int EXP_W   = 8,
    parameter int GUARD_Q = 3,
    parameter int SPLIT   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tbl_we,
    input  logic [N_IN-1:0]  tbl_addr,
    input  logic [W_W-1:0]   tbl_wdata,
    input  logic [EXP_W-1:0] exp_in,
    input  logic             in_valid,
    input  logic             in_start,
    input  logic [N_IN-1:0]  in_slice,
    output logic             slice_ready,
    output logic             busy,
    output logic             done,
    output logic [W_W:0]     res_mant,
    output logic [EXP_W-1:0] res_exp
);
    localparam bit TWO_CYC = (SPLIT == LDS_SPLIT_SEQ);

    logic             acc_step, acc_clr, half_latch, start_acc, wr_ok;
    logic [W_W-1:0]   word;
    logic [EXP_W-1:0] exp_q, exp_d;

    lds_ctrl #(.M_BITS(M_BITS), .TWO_CYC(TWO_CYC)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .acc_step(acc_step), .acc_clr(acc_clr), .half_latch(half_latch),
        .start_acc(start_acc), .slice_ready(slice_ready), .busy(busy), .done(done)
    );

    assign wr_ok = tbl_we && !busy && !start_acc;

    lds_table #(.N_IN(N_IN), .W_W(W_W), .SPLIT(SPLIT)) i_table (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .wr_addr(tbl_addr),
        .wr_data(tbl_wdata), .rd_slice(in_slice), .half_latch(half_latch),
        .rd_word(word)
    );

    lds_accum #(.W_W(W_W), .M_BITS(M_BITS)) i_accum (
        .clk(clk), .rst_n(rst_n), .step(acc_step), .clr(acc_clr),
        .word(word), .mant(res_mant)
    );

    always_comb begin
        exp_d = exp_q;
        if (start_acc) exp_d = exp_in + EXP_W'(GUARD_Q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) exp_q <= '0;
        else        exp_q <= exp_d;
    end

    assign res_exp = exp_q;

    // R5: an accepted start leaves the block running or finished
    p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> (busy || done));
    // R6: no table word changes under a running computation
    p_no_write_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tbl_we) |-> !wr_ok);
endmodule

// File: tb/test_lut_dot_serial.sv
module test_lut_dot_serial;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n;
    logic        va, sa;
    logic [3:0]  sla;
    logic [7:0]  expa;
    logic        we0, we1;
    logic [3:0]  a0, a1;
    logic [31:0] wd0, wd1;
    logic        vc, sc;
    logic [3:0]  slc;
    logic [7:0]  expc;
    logic        we2;
    logic [3:0]  a2;
    logic [31:0] wd2;

    logic        rdy0, busy0, done0, rdy1, busy1, done1, rdy2, busy2, done2;
    logic [32:0] mant0, mant1, mant2;
    logic [7:0]  exp0, exp1, exp2;

    lut_dot_serial #(.SPLIT(0)) i_lut_dot_serial (
        .clk(clk), .rst_n(rst_n), .tbl_we(we0), .tbl_addr(a0), .tbl_wdata(wd0),
        .exp_in(expa), .in_valid(va), .in_start(sa), .in_slice(sla),
        .slice_ready(rdy0), .busy(busy0), .done(done0), .res_mant(mant0), .res_exp(exp0));

    lut_dot_serial #(.SPLIT(1)) i_split_dual (
        .clk(clk), .rst_n(rst_n), .tbl_we(we1), .tbl_addr(a1), .tbl_wdata(wd1),
        .exp_in(expa), .in_valid(va), .in_start(sa), .in_slice(sla),
        .slice_ready(rdy1), .busy(busy1), .done(done1), .res_mant(mant1), .res_exp(exp1));

    lut_dot_serial #(.SPLIT(2)) i_split_seq (
        .clk(clk), .rst_n(rst_n), .tbl_we(we2), .tbl_addr(a2), .tbl_wdata(wd2),
        .exp_in(expc), .in_valid(vc), .in_start(sc), .in_slice(slc),
        .slice_ready(rdy2), .busy(busy2), .done(done2), .res_mant(mant2), .res_exp(exp2));

    int total = 0;
    int bad   = 0;
    logic [31:0] w [4];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exv);
        end
    endtask

    function automatic longint tfull(input logic [3:0] a);
        longint s = 0;
        for (int j = 0; j < 4; j++) if (a[j]) s += longint'(w[j]);
        return s;
    endfunction

    // behavioural reference for the two single-cycle instances
    logic [31:0] tab_m [16];
    bit          busy_m, done_m, acc_s, mon_on;
    int          cnt_m;
    longint      tot_m, mant_m;
    logic [7:0]  exp_m, expv_m;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) tab_m[i] = '0;
            busy_m = 0; done_m = 0; cnt_m = 0; tot_m = 0; mant_m = 0;
            exp_m = 0; expv_m = 0;
        end else begin
            acc_s  = !busy_m && va && sa;
            done_m = 0;
            if (we0 && !busy_m && !acc_s) tab_m[a0] = wd0;
            if (acc_s) begin
                tot_m  = longint'(tab_m[sla]);
                cnt_m  = 1;
                expv_m = expa + 8'd3;
                busy_m = 1;
            end else if (busy_m && va) begin
                tot_m = tot_m + (longint'(tab_m[sla]) << cnt_m);
                cnt_m++;
            end
            if (busy_m && cnt_m == 2) begin
                done_m = 1; busy_m = 0; cnt_m = 0;
                mant_m = tot_m >>> 1;
                exp_m  = expv_m;
            end
        end
    end

    always @(negedge clk) begin
        if (mon_on) begin
            chk(done0 === done_m, "R4 done", longint'(done0), longint'(done_m));
            chk(busy0 === busy_m, "R5 busy", longint'(busy0), longint'(busy_m));
            chk(done1 === done_m, "R8 done", longint'(done1), longint'(done_m));
            if (done_m) begin
                chk(mant0 == mant_m[32:0], "R3 mant", longint'(mant0), mant_m);
                chk(exp0 == exp_m, "R7 exp", longint'(exp0), longint'(exp_m));
                chk(mant1 == mant_m[32:0], "R8 mant", longint'(mant1), mant_m);
            end
        end
    end

    task automatic opa(input logic [3:0] s0, input logic [3:0] s1, input logic [7:0] e, input bit st2);
        @(negedge clk); va = 1; sa = 1; sla = s0; expa = e;
        @(negedge clk); sa = st2; sla = s1;
    endtask

    task automatic idle();
        @(negedge clk); va = 0; sa = 0; we0 = 0;
    endtask

    task automatic op2(input logic [3:0] s0, input logic [3:0] s1, input logic [7:0] e);
        longint ex;
        ex = (tfull(s0) + (tfull(s1) << 1)) >>> 1;
        @(negedge clk); vc = 1; sc = 1; slc = s0; expc = e;
        @(negedge clk);
        chk(rdy2 == 1'b0, "R9 ready low", longint'(rdy2), 0);
        vc = 0; sc = 0;
        @(negedge clk); vc = 1; slc = s1;
        @(negedge clk); vc = 0;
        chk(done2 == 1'b0, "R9 no early done", longint'(done2), 0);
        @(negedge clk);
        chk(done2 == 1'b1, "R9 done", longint'(done2), 1);
        chk(mant2 == ex[32:0], "R9 mant", longint'(mant2), ex);
        chk(exp2 == e + 8'd3, "R9 exp", longint'(exp2), longint'(e + 8'd3));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        w[0] = 32'h0ABC_DEF1; w[1] = 32'h0135_7924;
        w[2] = 32'h1000_0001; w[3] = 32'h0246_8ACE;
        rst_n = 0; va = 0; sa = 0; sla = 0; expa = 0; mon_on = 0;
        we0 = 0; we1 = 0; a0 = 0; a1 = 0; wd0 = 0; wd1 = 0;
        vc = 0; sc = 0; slc = 0; expc = 0; we2 = 0; a2 = 0; wd2 = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(busy0 == 0 && done0 == 0, "R10 idle", longint'({busy0, done0}), 0);
        chk(mant0 == 0, "R10 mant", longint'(mant0), 0);
        chk(exp0 == 0, "R10 exp", longint'(exp0), 0);
        chk(rdy2 == 1, "R10 ready", longint'(rdy2), 1);
        mon_on = 1;

        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            we0 = 1; a0 = 4'(i); wd0 = 32'(tfull(4'(i)));
            we1 = (i < 8); we2 = (i < 8);
            a1 = {i[2], 1'b0, i[1:0]}; a2 = a1;
            wd1 = i[2] ? ((i[0] ? w[2] : 32'd0) + (i[1] ? w[3] : 32'd0))
                       : ((i[0] ? w[0] : 32'd0) + (i[1] ? w[1] : 32'd0));
            wd2 = wd1;
        end
        @(negedge clk); we0 = 0; we1 = 0; we2 = 0;

        // R2: least significant slice first
        opa(4'h1, 4'h0, 8'h10, 0); idle();
        chk(mant0 == 33'(w[0] >> 1), "R2 lsb slice", longint'(mant0), longint'(w[0] >> 1));
        opa(4'h0, 4'h1, 8'h11, 0); idle();
        chk(mant0 == 33'(w[0]), "R2 msb slice", longint'(mant0), longint'(w[0]));
        // R1: one address mixes the selected weights
        opa(4'h5, 4'h0, 8'h12, 0); idle();
        chk(mant0 == 33'((longint'(w[0]) + longint'(w[2])) >>> 1), "R1 addr 5",
            longint'(mant0), (longint'(w[0]) + longint'(w[2])) >>> 1);
        opa(4'h0, 4'h0, 8'hFE, 0); idle();
        opa(4'hF, 4'hF, 8'h20, 0); idle();
        opa(4'hA, 4'h5, 8'h21, 0); idle();
        // R4: back-to-back, new start in the done cycle
        opa(4'h3, 4'hC, 8'h30, 0);
        opa(4'h9, 4'h6, 8'h31, 0); idle();
        // R5: start during run is data; idle valid without start ignored
        opa(4'h7, 4'hE, 8'h40, 1); idle();
        @(negedge clk); va = 1; sa = 0; sla = 4'hF;
        @(negedge clk); va = 0;
        chk(busy0 == 0 && done0 == 0, "R5 ignored slice", longint'({busy0, done0}), 0);
        // R6: writes in the start cycle and while busy are dropped
        @(negedge clk); va = 1; sa = 1; sla = 4'hF; expa = 8'h50;
        we0 = 1; a0 = 4'h3; wd0 = 32'hFFFF_FFFF;
        @(negedge clk); sa = 0; a0 = 4'hF;
        idle();
        chk(mant0 == 33'((tfull(4'hF) * 3) >>> 1), "R6 busy write",
            longint'(mant0), (tfull(4'hF) * 3) >>> 1);
        opa(4'h3, 4'h0, 8'h51, 0); idle();
        chk(mant0 == 33'(tfull(4'h3) >>> 1), "R6 start write",
            longint'(mant0), tfull(4'h3) >>> 1);
        // R9: single-memory split variant
        op2(4'h6, 4'h9, 8'h60);
        op2(4'hF, 4'h1, 8'hFF);
        op2(4'h0, 4'hB, 8'h02);
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule